// File: doc/BRIEF.md
# Scalable Multiply-Add Test Vector Generator

This block produces a deterministic test sequence for an array multiply-add unit of operand width `W`. The unit under test computes `S + A*B + C + 2^W*Cin`. The block drives the A, B and C operands, the 2W-bit S operand and the carry input. The stimulus is built per bit slice. Each slice `i` takes a 5-bit code that sets `A[i]`, `B[i]`, `C[i]`, `S[i+W]` and `S[i]`. One marker slice walks upward through the slices. Slices below the marker carry a trailing code and slices above it keep a base code. Four such groups of `W+1` vectors make up the whole sequence of `4W+4` vectors, so the sequence length grows linearly with the operand width.

Next to each vector, the block computes the expected 2W-bit result and its carry out from the operands it is driving. A comparator placed beside the unit under test can then flag a mismatch in the same cycle. A `start` pulse begins a run at vector 0. Each `advance` pulse moves to the next vector, and `last` marks the final vector of the sequence. The unit under test and the policy for latching errors lie outside this block.

Top module: `madd_vecgen`

## Requirements
- R1: After a synchronous active-low reset, `running` and `last` are low, and the outputs present vector 0: every slice carries the group-0 base code and `vec_cin` is 1.
- R2: Slice code bit 4 drives `vec_a[i]`, bit 3 drives `vec_b[i]`, bit 2 drives `vec_c[i]`, bit 1 drives `vec_s[i+W]` and bit 0 drives `vec_s[i]`.
- R3: The groups are numbered 0 to 3 and each is given as (base, marker, trailing, carry in): group 0 is (11100, 11000, 11101, 1), group 1 is (00011, 00111, 00010, 0), group 2 is (10100, 10000, 10101, 1) and group 3 is (01011, 01111, 01010, 0). Position 0 of each group applies the base code to every slice.
- R4: At position p of a group, for p from 1 to W, slice p-1 carries the marker code, lower slices carry the trailing code and higher slices carry the base code. The group's carry in is driven throughout.
- R5: A `start` pulse moves to vector 0 and sets `running` on the next cycle. It takes priority over `advance`.
- R6: While `running`, each cycle with `advance` high steps the vector index by one (index = group*(W+1) + position). A cycle without `advance` leaves the vector unchanged.
- R7: While `running` is low, `advance` has no effect on the outputs.
- R8: `last` is high exactly when `running` is high and the vector index is 4W+3. An `advance` at that vector returns to vector 0, and `running` stays high.
- R9: `exp_p` and `exp_cout` are the low 2W bits and bit 2W of `vec_s + vec_a*vec_b + vec_c + 2^W*vec_cin` for the vector currently presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run at vector 0 |
| advance | input | 1 | Step to the next vector |
| running | output | 1 | A run is in progress |
| last | output | 1 | Final vector of the sequence is presented |
| vec_a | output | W | Operand A |
| vec_b | output | W | Operand B |
| vec_c | output | W | Operand C |
| vec_s | output | 2W | Operand S |
| vec_cin | output | 1 | Carry input of the unit under test |
| exp_p | output | 2W | Expected result, low 2W bits |
| exp_cout | output | 1 | Expected carry out |

## Verification
The assertions check the sequencing on every cycle: a start lands on vector 0, a held or idle cycle keeps the index, a step from the final vector wraps with the run still active, the position never exceeds W, and group 0 position 0 always presents all-ones A with carry in set. The walking-marker slice pattern, the bit-to-pin mapping and the expected-result arithmetic can only be shown by the bench. It rebuilds every vector from the group code table at widths 4 and 8, and compares selected width-4 vectors against literal operand values.

// File: rtl/madd_vec_pkg.sv
// Package: slice code type and the per-group code table for the
// multiply-add test sequence. Code bit order is {A, B, C, S_hi, S_lo}.
package madd_vec_pkg;

    typedef logic [4:0] slice_code_t;

    typedef struct packed {
        slice_code_t base;
        slice_code_t marker;
        slice_code_t trail;
        logic        cin;
    } group_codes_t;

    // Return the code set of one of the four groups.
    function automatic group_codes_t group_codes(input logic [1:0] grp);
        group_codes_t g;
        case (grp)
            2'd0:    g = '{base: 5'b11100, marker: 5'b11000, trail: 5'b11101, cin: 1'b1};
            2'd1:    g = '{base: 5'b00011, marker: 5'b00111, trail: 5'b00010, cin: 1'b0};
            2'd2:    g = '{base: 5'b10100, marker: 5'b10000, trail: 5'b10101, cin: 1'b1};
            default: g = '{base: 5'b01011, marker: 5'b01111, trail: 5'b01010, cin: 1'b0};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/madd_seq_ctr.sv
// Sequence counter: holds the group (0..3) and the position inside the
// group (0..W). Assumes start has priority over advance; advance counts
// only while running.
module madd_seq_ctr #(
    parameter int W  = 4,
    localparam int PW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          advance,
    output logic          running,
    output logic [1:0]    grp,
    output logic [PW-1:0] pos,
    output logic          last
);
    localparam logic [PW-1:0] POS_MAX = PW'(W);

    logic at_end;
    assign at_end = (grp == 2'd3) && (pos == POS_MAX);

    // Step group/position, restart on start, wrap after the final vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            grp     <= 2'd0;
            pos     <= '0;
        end else if (start) begin
            running <= 1'b1;
            grp     <= 2'd0;
            pos     <= '0;
        end else if (running && advance) begin
            if (pos == POS_MAX) begin
                pos <= '0;
                grp <= grp + 2'd1;
            end else begin
                pos <= pos + PW'(1);
            end
        end
    end

    // Flag the final vector of the run.
    always_comb last = running && at_end;

endmodule

// File: rtl/madd_slice_enc.sv
// Slice encoder: picks the 5-bit code for bit slice IDX from the current
// group and position. Position 0 is all base; position p puts the marker on
// slice p-1, trailing below it, base above it.
module madd_slice_enc
    import madd_vec_pkg::*;
#(
    parameter int W   = 4,
    parameter int IDX = 0,
    localparam int PW = $clog2(W + 1)
) (
    input  logic [1:0]    grp,
    input  logic [PW-1:0] pos,
    output slice_code_t   code
);
    group_codes_t gc;
    int           mark_slice;

    // Select base, marker or trailing code for this slice.
    always_comb begin
        gc         = group_codes(grp);
        mark_slice = int'(pos) - 1;
        if (pos == '0 || mark_slice < IDX) begin
            code = gc.base;
        end else if (mark_slice == IDX) begin
            code = gc.marker;
        end else begin
            code = gc.trail;
        end
    end

endmodule

// File: rtl/madd_exp_model.sv
// Expected-result model: S + A*B + C + 2^W*Cin over 2W+1 bits.
// Assumes the inputs are the operands being applied this cycle.
module madd_exp_model #(
    parameter int W  = 4,
    localparam int RW = 2 * W + 1
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   c,
    input  logic [2*W-1:0] s,
    input  logic           cin,
    output logic [2*W-1:0] p,
    output logic           cout
);
    logic [RW-1:0] sum;

    // Add the four terms at full width and split off the carry.
    always_comb begin
        sum  = RW'(s) + (RW'(a) * RW'(b)) + RW'(c) + (RW'(cin) << W);
        p    = sum[2*W-1:0];
        cout = sum[2*W];
    end

endmodule

// File: rtl/madd_vecgen.sv
// Top: deterministic test vector generator for a W x W multiply-add array.
// Assumes a single clock, synchronous active-low reset, and pulse-style
// start/advance inputs. Outputs are combinational from the counter state.
module madd_vecgen
    import madd_vec_pkg::*;
#(
    parameter int W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           advance,
    output logic           running,
    output logic           last,
    output logic [W-1:0]   vec_a,
    output logic [W-1:0]   vec_b,
    output logic [W-1:0]   vec_c,
    output logic [2*W-1:0] vec_s,
    output logic           vec_cin,
    output logic [2*W-1:0] exp_p,
    output logic           exp_cout
);
    localparam int PW = $clog2(W + 1);

    logic [1:0]    grp;
    logic [PW-1:0] pos;
    group_codes_t  cur_gc;

    madd_seq_ctr #(.W(W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .advance (advance),
        .running (running),
        .grp     (grp),
        .pos     (pos),
        .last    (last)
    );

    // One encoder per slice; unpack its code onto the operand pins.
    for (genvar i = 0; i < W; i++) begin : g_slice
        slice_code_t code;

        madd_slice_enc #(.W(W), .IDX(i)) u_enc (
            .grp  (grp),
            .pos  (pos),
            .code (code)
        );

        assign vec_a[i]   = code[4];
        assign vec_b[i]   = code[3];
        assign vec_c[i]   = code[2];
        assign vec_s[i+W] = code[1];
        assign vec_s[i]   = code[0];
    end

    // Carry input is fixed per group.
    always_comb begin
        cur_gc  = group_codes(grp);
        vec_cin = cur_gc.cin;
    end

    madd_exp_model #(.W(W)) u_exp (
        .a    (vec_a),
        .b    (vec_b),
        .c    (vec_c),
        .s    (vec_s),
        .cin  (vec_cin),
        .p    (exp_p),
        .cout (exp_cout)
    );

endmodule

// File: rtl/madd_vecgen_chk.sv
// Checker for madd_vecgen sequencing; attached to the top with bind.
module madd_vecgen_chk #(
    parameter int W  = 4,
    localparam int PW = $clog2(W + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          advance,
    input logic          running,
    input logic          last,
    input logic [1:0]    grp,
    input logic [PW-1:0] pos,
    input logic [W-1:0]  vec_a,
    input logic          vec_cin
);
    // R5
    start_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (running && grp == 2'd0 && pos == '0));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !advance && !start) |=> ($stable(grp) && $stable(pos) && running));

    // R7
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> ($stable(grp) && $stable(pos) && !running));

    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && advance && !start) |=> (running && grp == 2'd0 && pos == '0 && !last));

    // R4
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pos) <= W);

    // R3
    first_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == 2'd0 && pos == '0) |-> (vec_a == '1 && vec_cin));

endmodule

bind madd_vecgen madd_vecgen_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .advance (advance),
    .running (running),
    .last    (last),
    .grp     (grp),
    .pos     (pos),
    .vec_a   (vec_a),
    .vec_cin (vec_cin)
);

// File: tb/sim_madd_vecgen.sv
`timescale 1ns/1ps
module sim_madd_vecgen;

    typedef struct {
        logic [7:0]  a, b, c;
        logic [15:0] s;
        logic        cin;
        logic [15:0] p;
        logic        cout;
    } vec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic advance = 1'b0;

    always #2.5 clk = ~clk;

    logic       run0, last0, cin0, cout0;
    logic [3:0] a0, b0, c0;
    logic [7:0] s0, p0;
    logic       run1, last1, cin1, cout1;
    logic [7:0] a1, b1, c1;
    logic [15:0] s1, p1;

    madd_vecgen #(.W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
        .running(run0), .last(last0), .vec_a(a0), .vec_b(b0), .vec_c(c0),
        .vec_s(s0), .vec_cin(cin0), .exp_p(p0), .exp_cout(cout0));

    madd_vecgen #(.W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
        .running(run1), .last(last1), .vec_a(a1), .vec_b(b1), .vec_c(c1),
        .vec_s(s1), .vec_cin(cin1), .exp_p(p1), .exp_cout(cout1));

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit mrun = 1'b0;
    int i4 = 0;
    int i8 = 0;

    logic [4:0] base_t[4]  = '{5'b11100, 5'b00011, 5'b10100, 5'b01011};
    logic [4:0] mark_t[4]  = '{5'b11000, 5'b00111, 5'b10000, 5'b01111};
    logic [4:0] trail_t[4] = '{5'b11101, 5'b00010, 5'b10101, 5'b01010};
    logic       cin_t[4]   = '{1'b1, 1'b0, 1'b1, 1'b0};

    // Build the expected vector at width n for sequence index idx.
    function automatic vec_t model(int n, int idx);
        vec_t v;
        int g = idx / (n + 1);
        int p = idx % (n + 1);
        longint tot;
        logic [4:0] cd;
        v = '{default: '0};
        for (int i = 0; i < n; i++) begin
            if (p == 0 || i > p - 1) cd = base_t[g];
            else if (i == p - 1)     cd = mark_t[g];
            else                     cd = trail_t[g];
            v.a[i]   = cd[4];
            v.b[i]   = cd[3];
            v.c[i]   = cd[2];
            v.s[i+n] = cd[1];
            v.s[i]   = cd[0];
        end
        v.cin = cin_t[g];
        tot = longint'(v.s) + longint'(v.a) * longint'(v.b) + longint'(v.c)
              + (longint'(v.cin) << n);
        v.p    = 16'(tot & ((longint'(1) << (2 * n)) - 1));
        v.cout = 1'(tot >> (2 * n));
        return v;
    endfunction

    task automatic chk(string req, bit ok, string act, string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    // Compare both instances against the model for the current state.
    task automatic check_all(string tag);
        vec_t e4 = model(4, i4);
        vec_t e8 = model(8, i8);
        string req;
        req = (i4 % 5 == 0) ? "R3" : "R4";
        chk({req, " w4 operands ", tag},
            {a0, b0, c0, s0, cin0} == {e4.a[3:0], e4.b[3:0], e4.c[3:0], e4.s[7:0], e4.cin},
            $sformatf("%h %h %h %h %b", a0, b0, c0, s0, cin0),
            $sformatf("%h %h %h %h %b", e4.a[3:0], e4.b[3:0], e4.c[3:0], e4.s[7:0], e4.cin));
        chk({"R9 w4 result ", tag}, {p0, cout0} == {e4.p[7:0], e4.cout},
            $sformatf("%h/%b", p0, cout0), $sformatf("%h/%b", e4.p[7:0], e4.cout));
        req = (i8 % 9 == 0) ? "R3" : "R4";
        chk({req, " w8 operands ", tag},
            {a1, b1, c1, s1, cin1} == {e8.a, e8.b, e8.c, e8.s, e8.cin},
            $sformatf("%h %h %h %h %b", a1, b1, c1, s1, cin1),
            $sformatf("%h %h %h %h %b", e8.a, e8.b, e8.c, e8.s, e8.cin));
        chk({"R9 w8 result ", tag}, {p1, cout1} == {e8.p, e8.cout},
            $sformatf("%h/%b", p1, cout1), $sformatf("%h/%b", e8.p, e8.cout));
        chk({"R8 last/running ", tag},
            {run0, last0, run1, last1} == {mrun, mrun && i4 == 19, mrun, mrun && i8 == 35},
            $sformatf("%b%b%b%b", run0, last0, run1, last1),
            $sformatf("%b%b%b%b", mrun, mrun && i4 == 19, mrun, mrun && i8 == 35));
    endtask

    // Apply one cycle of inputs, update the model, then check.
    task automatic step(bit st, bit adv, string tag);
        @(negedge clk);
        start = st;
        advance = adv;
        @(negedge clk);
        start = 1'b0;
        advance = 1'b0;
        if (st) begin
            mrun = 1'b1; i4 = 0; i8 = 0;
        end else if (mrun && adv) begin
            i4 = (i4 + 1) % 20;
            i8 = (i8 + 1) % 36;
        end
        check_all(tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state is vector 0, idle
        chk("R1 reset state", {run0, last0, a0, cin0} == {1'b0, 1'b0, 4'hF, 1'b1},
            $sformatf("%b%b%h%b", run0, last0, a0, cin0), "00f1");
        check_all("reset R1");
        // R7: advance while idle is ignored
        step(1'b0, 1'b1, "idle advance R7");
        step(1'b0, 1'b1, "idle advance R7");
        // R5: start
        step(1'b1, 1'b0, "start R5");
        // R6: full walk plus wrap (R8)
        for (int k = 0; k < 24; k++) begin
            step(1'b0, 1'b1, "walk R6");
            // R2: literal width-4 vectors
            if (i4 == 6)
                chk("R2 vector 6 literal", {a0, b0, c0, s0, cin0, p0, cout0} ==
                    {4'h0, 4'h0, 4'h1, 8'hFF, 1'b0, 8'h00, 1'b1},
                    $sformatf("%h %h %h %h %b %h %b", a0, b0, c0, s0, cin0, p0, cout0),
                    "0 0 1 ff 0 00 1");
            if (i4 == 19)
                chk("R2 vector 19 literal", {a0, b0, c0, s0, cin0} ==
                    {4'h0, 4'hF, 4'h8, 8'hF8, 1'b0},
                    $sformatf("%h %h %h %h %b", a0, b0, c0, s0, cin0), "0 f 8 f8 0");
        end
        // R6: hold without advance
        step(1'b0, 1'b0, "hold R6");
        step(1'b0, 1'b0, "hold R6");
        // R5: start beats advance mid-run
        step(1'b1, 1'b1, "start priority R5");
        // Random mix
        for (int k = 0; k < 400; k++) begin
            bit st = ($urandom % 25) == 0;
            bit adv = ($urandom % 3) != 0;
            step(st, adv, "random");
        end
        // Walk width-8 through the wrap too (R8)
        step(1'b1, 1'b0, "restart R5");
        for (int k = 0; k < 40; k++) step(1'b0, 1'b1, "w8 walk R8");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule